// File: doc/BRIEF.md
# Logarithmic-Depth Carry Lookahead Adder

This block adds two unsigned (or two's-complement) operands of `WIDTH` bits plus a carry input. No carry passes bit by bit. Each bit position forms a local generate (`a & b`) and a local propagate (`a ^ b`). A binary tree of merge cells then joins neighbouring bit ranges into range-wide generate and propagate terms. On the way back down, the same tree hands each range the carry that enters it. The lower half of any range takes the range's incoming carry. The upper half takes the lower half's generate, or the lower half's propagate ANDed with the incoming carry. Each sum bit is its propagate XORed with its carry.

`WIDTH` must be a power of two, so the tree is perfectly balanced and has log2(`WIDTH`) levels. The carry out, the sum and the whole-word generate and propagate terms are captured in one output register stage, which has a synchronous active-high reset. A wider adder can use the whole-word generate and propagate terms as one leaf of a higher lookahead level.

Top module: `cla_adder`

## Requirements
- R1: One clock after an edge that samples `a`, `b`, `cin` with `rst` low, `sum` equals (`a` + `b` + `cin`) modulo 2^`WIDTH`.
- R2: At that same point, `cout` equals bit `WIDTH` of `a` + `b` + `cin`, which is the carry out of the most significant position.
- R3: `blk_p` is 1 exactly when `a[i] ^ b[i]` is 1 for every bit i of the sampled operands.
- R4: `blk_g` is 1 exactly when `a` + `b` alone, with the carry input ignored, reaches 2^`WIDTH` or more.
- R5: `blk_g` and `blk_p` are never 1 in the same cycle.
- R6: When `b` is the bitwise complement of `a` and `cin` is 1, the carry travels across the whole word: `sum` is 0 and `cout` is 1. With `cin` at 0, `sum` is all ones and `cout` is 0.
- R7: A clock edge with `rst` high sets `sum`, `cout`, `blk_g` and `blk_p` to 0, whatever the inputs are.
- R8: The result is correct for every `WIDTH` that is a power of two. This holds for the whole input space at `WIDTH` = 4, and at 8 and 16 over the operand corners and random operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top bit |
| blk_g | output | 1 | Registered whole-word generate |
| blk_p | output | 1 | Registered whole-word propagate |

## Verification
On every cycle after reset, the assertions compare the registered sum and carry with an arithmetic reference built from the previous cycle's inputs. They also check the whole-word propagate against the AND of the bitwise XOR, check that generate and propagate never occur together, and check the reset clear. The bench scenarios are what cover the width dimension: the full input space at four bits, and full-length carry chains, all-ones and zero operands at eight and sixteen bits. The named propagate-through corner of R6 is also shown only by a directed bench case.

// File: rtl/cla_pkg.sv
package cla_pkg;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cla_pg_gen.sv
module cla_pg_gen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] g,
  output logic [WIDTH-1:0] p
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign g[i] = a[i] & b[i];
    assign p[i] = a[i] ^ b[i];
  end

endmodule

// File: rtl/cla_node.sv
module cla_node #(
  parameter int W = 8
) (
  input  logic [W-1:0] g,
  input  logic [W-1:0] p,
  input  logic         ci,
  output logic [W-1:0] c,
  output logic         gg,
  output logic         pp
);

  if (W == 1) begin : g_leaf
    assign c[0] = ci;
    assign gg   = g[0];
    assign pp   = p[0];
  end else begin : g_split
    localparam int H = W / 2;
    logic g_lo, p_lo, g_hi, p_hi, c_mid;

    cla_node #(.W(H)) u_lo (
      .g (g[H-1:0]),
      .p (p[H-1:0]),
      .ci(ci),
      .c (c[H-1:0]),
      .gg(g_lo),
      .pp(p_lo)
    );

    // carry entering the upper half
    assign c_mid = g_lo | (p_lo & ci);

    cla_node #(.W(W - H)) u_hi (
      .g (g[W-1:H]),
      .p (p[W-1:H]),
      .ci(c_mid),
      .c (c[W-1:H]),
      .gg(g_hi),
      .pp(p_hi)
    );

    assign gg = g_hi | (p_hi & g_lo);
    assign pp = p_lo & p_hi;
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             blk_g,
  output logic             blk_p
);

  if (!is_pow2(WIDTH)) begin : g_bad_width
    $error("cla_adder: WIDTH must be a power of two");
  end

  logic [WIDTH-1:0] bit_g, bit_p, carry;
  logic             word_g, word_p;

  cla_pg_gen #(.WIDTH(WIDTH)) u_pg (
    .a(a),
    .b(b),
    .g(bit_g),
    .p(bit_p)
  );

  cla_node #(.W(WIDTH)) u_tree (
    .g (bit_g),
    .p (bit_p),
    .ci(cin),
    .c (carry),
    .gg(word_g),
    .pp(word_p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum   <= '0;
      cout  <= 1'b0;
      blk_g <= 1'b0;
      blk_p <= 1'b0;
    end else begin
      sum   <= bit_p ^ carry;
      cout  <= word_g | (word_p & cin);
      blk_g <= word_g;
      blk_p <= word_p;
    end
  end

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic             blk_g,
  input logic             blk_p
);

  a_r1_sum_value: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum == WIDTH'($past(a) + $past(b) + WIDTH'($past(cin))));

  a_r2_carry_out: assert property (@(posedge clk) disable iff (rst)
    !rst |=> {cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + (WIDTH+1)'($past(cin))));

  a_r3_word_propagate: assert property (@(posedge clk) disable iff (rst)
    !rst |=> blk_p == (&($past(a) ^ $past(b))));

  a_r4_word_generate: assert property (@(posedge clk) disable iff (rst)
    !rst |=> blk_g == (({1'b0, $past(a)} + {1'b0, $past(b)}) >> WIDTH != 0));

  a_r5_g_p_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(blk_g && blk_p));

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (sum == '0) && !cout && !blk_g && !blk_p);

endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_cla_adder.sv
module test_cla_adder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0]  a4, b4, s4;
  logic [7:0]  a8, b8, s8;
  logic [15:0] a16, b16, s16;
  logic c4, c8, c16, co4, co8, co16, g4, g8, g16, p4, p8, p16;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cla_adder #(.WIDTH(8)) i_cla_adder (
    .clk(clk), .rst(rst), .a(a8), .b(b8), .cin(c8),
    .sum(s8), .cout(co8), .blk_g(g8), .blk_p(p8));

  cla_adder #(.WIDTH(4)) i_cla_adder_w4 (
    .clk(clk), .rst(rst), .a(a4), .b(b4), .cin(c4),
    .sum(s4), .cout(co4), .blk_g(g4), .blk_p(p4));

  cla_adder #(.WIDTH(16)) i_cla_adder_w16 (
    .clk(clk), .rst(rst), .a(a16), .b(b16), .cin(c16),
    .sum(s16), .cout(co16), .blk_g(g16), .blk_p(p16));

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_w(input int w, input longint unsigned a, input longint unsigned b,
                         input bit ci, input longint unsigned s, input bit co,
                         input bit g, input bit p);
    longint unsigned mask, tot, part;
    string tag;
    mask = (64'd1 << w) - 1;
    tot  = (a & mask) + (b & mask) + ci;
    part = (a & mask) + (b & mask);
    tag  = $sformatf("w%0d", w);
    check("R1 R8", {tag, " sum"}, s, tot & mask);
    check("R2", {tag, " cout"}, co, (tot >> w) & 1);
    check("R3", {tag, " blk_p"}, p, (((a ^ b) & mask) == mask) ? 1 : 0);
    check("R4", {tag, " blk_g"}, g, (part >> w) & 1);
    check("R5", {tag, " g&p"}, g & p, 0);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (rst) begin
      check("R7", "w4 reset", {s4, co4, g4, p4}, 0);
      check("R7", "w8 reset", {s8, co8, g8, p8}, 0);
      check("R7", "w16 reset", {s16, co16, g16, p16}, 0);
    end else begin
      check_w(4, a4, b4, c4, s4, co4, g4, p4);
      check_w(8, a8, b8, c8, s8, co8, g8, p8);
      check_w(16, a16, b16, c16, s16, co16, g16, p16);
    end
    @(negedge clk);
  endtask

  task automatic rand_all();
    a4 = 4'($urandom); b4 = 4'($urandom); c4 = 1'($urandom);
    a8 = 8'($urandom); b8 = 8'($urandom); c8 = 1'($urandom);
    a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5eed_c1a0));
    // R7: reset holds outputs at zero despite busy inputs
    a4 = 4'hf; b4 = 4'h1; c4 = 1'b1;
    a8 = 8'hff; b8 = 8'hff; c8 = 1'b1;
    a16 = 16'hffff; b16 = 16'h0001; c16 = 1'b1;
    step();
    step();
    rst = 1'b0;

    // R8: full input space at four bits, random at eight and sixteen
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        for (int k = 0; k < 2; k++) begin
          rand_all();
          a4 = 4'(i); b4 = 4'(j); c4 = 1'(k);
          step();
        end
      end
    end

    // R6: carry through an all-propagate word, cin = 1 then 0
    for (int k = 1; k >= 0; k--) begin
      a4 = 4'h5; b4 = ~a4; c4 = 1'(k);
      a8 = 8'h3c; b8 = ~a8; c8 = 1'(k);
      a16 = 16'ha55a; b16 = ~a16; c16 = 1'(k);
      step();
      @(posedge clk); #1;
      check("R6", "w4 sum", s4, k ? 0 : 4'hf);
      check("R6", "w4 cout", co4, k);
      check("R6", "w8 sum", s8, k ? 0 : 8'hff);
      check("R6", "w8 cout", co8, k);
      check("R6", "w16 sum", s16, k ? 0 : 16'hffff);
      check("R6", "w16 cout", co16, k);
      @(negedge clk);
    end

    // operand corners at every width
    for (int m = 0; m < 6; m++) begin
      case (m)
        0: begin a8 = 8'h00; b8 = 8'h00; a16 = 16'h0000; b16 = 16'h0000; end
        1: begin a8 = 8'hff; b8 = 8'hff; a16 = 16'hffff; b16 = 16'hffff; end
        2: begin a8 = 8'hff; b8 = 8'h01; a16 = 16'hffff; b16 = 16'h0001; end
        3: begin a8 = 8'h80; b8 = 8'h80; a16 = 16'h8000; b16 = 16'h8000; end
        4: begin a8 = 8'h7f; b8 = 8'h7f; a16 = 16'h7fff; b16 = 16'h7fff; end
        default: begin a8 = 8'h0f; b8 = 8'hf0; a16 = 16'h00ff; b16 = 16'hff00; end
      endcase
      for (int k = 0; k < 2; k++) begin
        a4 = a8[3:0]; b4 = b8[3:0]; c4 = 1'(k); c8 = 1'(k); c16 = 1'(k);
        step();
      end
    end

    // random operands at the wider widths
    for (int n = 0; n < 3000; n++) begin
      rand_all();
      step();
    end

    // R7: reset in mid-run clears again
    rst = 1'b1;
    a8 = 8'hff; b8 = 8'h01; c8 = 1'b1;
    step();
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule